// File: doc/BRIEF.md
# Move-Only Processor Core

This core runs programs that contain only move instructions. An instruction has no operation field. It holds two data addresses: a source in the upper half and a destination in the lower half. The core fetches one pair, reads the word at the source and writes that word to the destination. All arithmetic comes from side effects of those moves. Writing a word to the input port of an accumulator or a multiplier makes that unit compute, and reading the unit's result port returns the value. The program counter is itself a data address, so a jump is a move into that address.

The data address space is split into pages of 256 words. Each page holds its own accumulator and its own multiplier at the same low offsets, and every copy keeps separate state. Every other address is ordinary data memory, which sits outside the core on a port with a one-cycle read latency. The instruction store is also outside the core and is read synchronously. The core has no interlocks. Software must not read a multiplier result before the multiply has finished.

Top module: `movproc`

## Requirements
- R1: An instruction word is {src[19:10], dst[9:0]}. Executing it writes the word read from src to dst. An address that is not a unit port, the program counter or the halt address is ordinary memory, read and written on the data port.
- R2: Each move takes exactly three cycles: fetch, load and store. After a move whose destination is not the program counter, the program counter grows by one.
- R3: A write to page offset 0 adds the word to that page's accumulator. Reading offset 4 returns the sum. A write to offset 16 sets the sum to zero.
- R4: Offset 8 is the multiplier input. The first write latches operand A and the second write latches operand B. Reading offset 12 returns the low 16 bits of A*B. The result register changes two clock edges after the edge that stored B.
- R5: Each 256-word page (0, 256, 512, 768) has its own accumulator and multiplier, and their states are independent.
- R6: The program counter sits at address 64. A move into it loads the low 8 bits of the word as the next instruction index and skips the increment. Reading address 64 returns the index of the move being executed.
- R7: A destination of 1023 halts the core. done rises and stays high, and no further data write is issued.
- R8: Reset sets the program counter to 0, sets every accumulator and multiplier to zero and holds done low.
- R9: A unit port address never appears as a data write. Writes to result offsets 4 and 12 are ignored. Reads of offsets 0, 8 and 16 return zero.
- R10: When one move reads and writes the same unit, the value it moves is the unit's output from before the move. For example, moving offset 4 into offset 0 doubles the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Index of the instruction to fetch |
| imem_rdata | input | 20 | Instruction word, valid one cycle after imem_addr |
| dmem_addr | output | 10 | Data memory address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 16 | Data memory write word |
| dmem_rdata | input | 16 | Data memory read word, valid one cycle after dmem_addr |
| done | output | 1 | Core has halted |

## Verification
Within one store cycle, a move can read a unit's output and write into that same unit's input. The test provokes this by moving the accumulator sum back into the accumulator input. It then judges the doubled sum when that sum is copied out to memory. A jump move also reads the program counter in the same store cycle in which the next index is chosen. The test uses a move that copies the program counter to memory after a jump, and it must see the index of the jump target, with the skipped moves producing no writes. Every data write is matched in order against a queue of expected address and data pairs. Any write that the queue does not expect counts as a failure.

// File: rtl/movproc_pkg.sv
package movproc_pkg;
    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_LOAD  = 2'd1,
        ST_STORE = 2'd2,
        ST_HALT  = 2'd3
    } st_e;

    // low-offset map inside each 256-word page
    localparam int OFF_ACC_IN  = 0;
    localparam int OFF_ACC_SUM = 4;
    localparam int OFF_MUL_IN  = 8;
    localparam int OFF_MUL_RES = 12;
    localparam int OFF_ACC_CLR = 16;
endpackage

// File: rtl/movproc_acc.sv
module movproc_acc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic          clr_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] sum
);
    logic [DW-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr_en)      sum_d = '0;
        else if (add_en) sum_d = sum_q + din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;
endmodule

// File: rtl/movproc_mul.sv
module movproc_mul #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] res
);
    typedef struct packed {
        logic          phase;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          go1;
        logic [DW-1:0] prod;
        logic          go2;
        logic [DW-1:0] res;
    } mul_s;

    mul_s d, q;

    always_comb begin
        d     = q;
        d.go1 = 1'b0;
        d.go2 = 1'b0;
        if (wr_en) begin
            if (!q.phase) begin
                d.a     = din;
                d.phase = 1'b1;
            end else begin
                d.b     = din;
                d.phase = 1'b0;
                d.go1   = 1'b1;
            end
        end
        if (q.go1) begin
            d.prod = q.a * q.b;
            d.go2  = 1'b1;
        end
        if (q.go2) d.res = q.prod;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res = q.res;
endmodule

// File: rtl/movproc.sv
module movproc
    import movproc_pkg::*;
#(
    parameter int AW      = 10,
    parameter int DW      = 16,
    parameter int IAW     = 8,
    parameter int PB      = 8,
    parameter int PC_ADDR = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [IAW-1:0]  imem_addr,
    input  logic [2*AW-1:0] imem_rdata,
    output logic [AW-1:0]   dmem_addr,
    output logic            dmem_we,
    output logic [DW-1:0]   dmem_wdata,
    input  logic [DW-1:0]   dmem_rdata,
    output logic            done
);
    localparam int PGW   = AW - PB;
    localparam int NUNIT = 1 << PGW;
    localparam logic [AW-1:0] HALT_ADDR = {AW{1'b1}};
    localparam logic [AW-1:0] PC_A      = AW'(PC_ADDR);

    typedef struct packed {
        st_e            st;
        logic [IAW-1:0] pc;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic           done;
    } core_s;

    core_s d, q;

    function automatic logic is_port(input logic [AW-1:0] a);
        logic [PB-1:0] o;
        o = a[PB-1:0];
        return (o == PB'(OFF_ACC_IN))  || (o == PB'(OFF_ACC_SUM)) ||
               (o == PB'(OFF_MUL_IN))  || (o == PB'(OFF_MUL_RES)) ||
               (o == PB'(OFF_ACC_CLR));
    endfunction

    logic [DW-1:0]    acc_sum [NUNIT];
    logic [DW-1:0]    mul_res [NUNIT];
    logic [NUNIT-1:0] acc_add, acc_clr, mul_wr;
    logic [DW-1:0]    mv_val;
    logic             store_act, dst_pc, dst_halt, dst_port;

    // value moved in the store cycle, taken before any unit updates
    always_comb begin
        mv_val = dmem_rdata;
        if (q.src == PC_A) begin
            mv_val = {{(DW-IAW){1'b0}}, q.pc};
        end else if (is_port(q.src)) begin
            mv_val = '0;
            for (int g = 0; g < NUNIT; g++) begin
                if (q.src[AW-1:PB] == PGW'(g)) begin
                    if (q.src[PB-1:0] == PB'(OFF_ACC_SUM)) mv_val = acc_sum[g];
                    if (q.src[PB-1:0] == PB'(OFF_MUL_RES)) mv_val = mul_res[g];
                end
            end
        end
    end

    assign store_act = (q.st == ST_STORE);
    assign dst_halt  = (q.dst == HALT_ADDR);
    assign dst_pc    = (q.dst == PC_A);
    assign dst_port  = is_port(q.dst);

    always_comb begin
        acc_add = '0;
        acc_clr = '0;
        mul_wr  = '0;
        for (int g = 0; g < NUNIT; g++) begin
            if (store_act && dst_port && q.dst[AW-1:PB] == PGW'(g)) begin
                acc_add[g] = (q.dst[PB-1:0] == PB'(OFF_ACC_IN));
                acc_clr[g] = (q.dst[PB-1:0] == PB'(OFF_ACC_CLR));
                mul_wr[g]  = (q.dst[PB-1:0] == PB'(OFF_MUL_IN));
            end
        end
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_FETCH: d.st = ST_LOAD;
            ST_LOAD: begin
                d.src = imem_rdata[2*AW-1:AW];
                d.dst = imem_rdata[AW-1:0];
                d.st  = ST_STORE;
            end
            ST_STORE: begin
                if (dst_halt) begin
                    d.st   = ST_HALT;
                    d.done = 1'b1;
                end else begin
                    d.st = ST_FETCH;
                    d.pc = dst_pc ? mv_val[IAW-1:0] : q.pc + 1'b1;
                end
            end
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_FETCH, pc: '0, src: '0, dst: '0, done: 1'b0};
        else        q <= d;
    end

    generate
        for (genvar g = 0; g < NUNIT; g++) begin : g_unit
            movproc_acc #(.DW(DW)) u_acc (
                .clk(clk), .rst_n(rst_n), .add_en(acc_add[g]),
                .clr_en(acc_clr[g]), .din(mv_val), .sum(acc_sum[g])
            );
            movproc_mul #(.DW(DW)) u_mul (
                .clk(clk), .rst_n(rst_n), .wr_en(mul_wr[g]),
                .din(mv_val), .res(mul_res[g])
            );
        end
    endgenerate

    assign imem_addr  = q.pc;
    assign dmem_addr  = (q.st == ST_LOAD)  ? imem_rdata[2*AW-1:AW] :
                        (q.st == ST_STORE) ? q.dst : '0;
    assign dmem_we    = store_act && !dst_halt && !dst_pc && !dst_port;
    assign dmem_wdata = mv_val;
    assign done       = q.done;
endmodule

// File: rtl/movproc_chk.sv
module movproc_chk
    import movproc_pkg::*;
#(
    parameter int AW      = 10,
    parameter int IAW     = 8,
    parameter int PB      = 8,
    parameter int PC_ADDR = 64
) (
    input logic           clk,
    input logic           rst_n,
    input st_e            st,
    input logic [IAW-1:0] pc,
    input logic [AW-1:0]  dst,
    input logic [AW-1:0]  dmem_addr,
    input logic           dmem_we,
    input logic           done
);
    // R2
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |=> (st == ST_STORE));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STORE && dst != AW'(PC_ADDR) && dst != {AW{1'b1}})
        |=> (pc == $past(pc) + 1'b1));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !dmem_we && $stable(pc)));

    // R9
    port_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (st == ST_STORE && dmem_addr != AW'(PC_ADDR) &&
                     dmem_addr[PB-1:0] != PB'(OFF_ACC_IN)  &&
                     dmem_addr[PB-1:0] != PB'(OFF_ACC_SUM) &&
                     dmem_addr[PB-1:0] != PB'(OFF_MUL_IN)  &&
                     dmem_addr[PB-1:0] != PB'(OFF_MUL_RES) &&
                     dmem_addr[PB-1:0] != PB'(OFF_ACC_CLR)));

    // R8
    reset_pc_chk: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !done));
endmodule

bind movproc movproc_chk #(.AW(AW), .IAW(IAW), .PB(PB), .PC_ADDR(PC_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(q.st), .pc(q.pc), .dst(q.dst),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .done(done)
);

// File: tb/movproc_tb.sv
module movproc_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr;
    logic [19:0] imem_rdata;
    logic [9:0]  dmem_addr;
    logic        dmem_we;
    logic [15:0] dmem_wdata;
    logic [15:0] dmem_rdata;
    logic        done;

    logic [19:0] prog [256];
    logic [15:0] mem  [1024];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic [9:0]  a;
        logic [15:0] d;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    movproc u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .done(done)
    );

    always @(posedge clk) begin
        imem_rdata <= prog[imem_addr];
        if (dmem_we) mem[dmem_addr] <= dmem_wdata;
        dmem_rdata <= mem[dmem_addr];
    end

    // monitor: every data write must match the head of the expected queue
    always @(negedge clk) begin
        if (rst_n && dmem_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected write: actual addr %0d data %0d expected none",
                         dmem_addr, dmem_wdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (dmem_addr !== e.a || dmem_wdata !== e.d) begin
                    errors++;
                    $display("FAIL %s: actual addr %0d data %0d expected addr %0d data %0d",
                             e.tag, dmem_addr, dmem_wdata, e.a, e.d);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    function automatic logic [19:0] mv(input int s, input int d);
        return {10'(s), 10'(d)};
    endfunction

    task automatic expect_wr(input int a, input int d, input string tag);
        exp_t e;
        e.a = 10'(a); e.d = 16'(d); e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = mv(0, 1023);
    endtask

    task automatic run_prog(input string name);
        int n;
        logic [7:0] pc_at_done;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(done === 1'b0 && imem_addr === 8'd0 && dmem_we === 1'b0,
              {"R8 reset state ", name}, int'(imem_addr), 0);
        rst_n = 1'b1;
        n = 0;
        while (done !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(done === 1'b1, {"R7 halt reached ", name}, int'(done), 1);
        pc_at_done = imem_addr;
        repeat (12) @(negedge clk);
        check(done === 1'b1 && imem_addr === pc_at_done,
              {"R7 halt holds ", name}, int'(imem_addr), int'(pc_at_done));
        check(exp_q.size() == 0, {"R1 all writes seen ", name}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[100] = 16'd5; mem[101] = 16'd7; mem[102] = 16'd3; mem[103] = 16'd4;
        mem[110] = 16'd6; mem[111] = 16'd9;

        // program 1: accumulator, plain memory, same-cycle read/write of a unit
        clear_prog();
        prog[0] = mv(100, 16);   // R3 clear
        prog[1] = mv(100, 0);    // acc = 5
        prog[2] = mv(101, 0);    // acc = 12
        prog[3] = mv(4, 200);    expect_wr(200, 12, "R3 accumulate");
        prog[4] = mv(4, 0);      // R10 doubles to 24
        prog[5] = mv(4, 201);    expect_wr(201, 24, "R10 sum into own input");
        prog[6] = mv(101, 20);   expect_wr(20, 7, "R1 plain memory move");
        prog[7] = mv(20, 202);   expect_wr(202, 7, "R1 read back plain memory");
        prog[8] = mv(100, 16);   // clear
        prog[9] = mv(4, 203);    expect_wr(203, 0, "R3 clear");
        prog[10] = mv(100, 1023);
        run_prog("p1");

        // program 2: multipliers in two pages, page independence, reset of units
        clear_prog();
        prog[0] = mv(100, 8);
        prog[1] = mv(101, 8);    // 5*7
        prog[2] = mv(102, 264);
        prog[3] = mv(103, 264);  // 3*4 in page 1
        prog[4] = mv(12, 210);   expect_wr(210, 35, "R4 multiplier page 0");
        prog[5] = mv(268, 211);  expect_wr(211, 12, "R5 multiplier page 1");
        prog[6] = mv(4, 212);    expect_wr(212, 0, "R8 accumulator zero after reset");
        prog[7] = mv(102, 256);  // page 1 acc = 3
        prog[8] = mv(4, 213);    expect_wr(213, 0, "R5 page 0 accumulator untouched");
        prog[9] = mv(260, 214);  expect_wr(214, 3, "R5 page 1 accumulator");
        prog[10] = mv(12, 776);  // page 3 operand A = 35
        prog[11] = mv(12, 776);  // 35*35
        prog[12] = mv(780, 215); expect_wr(215, 1225, "R4 result from a unit port");
        prog[13] = mv(100, 1023);
        run_prog("p2");

        // program 3: jumps, program-counter read, ignored port accesses
        clear_prog();
        prog[0] = mv(110, 64);   // R6 jump to 6
        for (int i = 1; i < 6; i++) prog[i] = mv(111, 220);
        prog[6] = mv(64, 221);   expect_wr(221, 6, "R6 read of program counter");
        prog[7] = mv(111, 222);  expect_wr(222, 9, "R2 step after jump target");
        prog[8] = mv(110, 4);    // R9 write to sum port ignored
        prog[9] = mv(4, 223);    expect_wr(223, 0, "R9 write to sum ignored");
        prog[10] = mv(110, 12);
        prog[11] = mv(12, 224);  expect_wr(224, 0, "R9 write to product ignored");
        prog[12] = mv(0, 225);   expect_wr(225, 0, "R9 read of input port");
        prog[13] = mv(16, 226);  expect_wr(226, 0, "R9 read of clear port");
        prog[14] = mv(64, 227);  expect_wr(227, 14, "R2 counter advance by one");
        prog[15] = mv(100, 1023);
        prog[16] = mv(111, 228); // beyond halt, must not run
        run_prog("p3");

        check(mem[221] === 16'd6 && mem[220] === 16'd0, "R6 skipped moves final memory",
              int'(mem[220]), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule